// File: doc/BRIEF.md
# Bridge Prefetchable Window Decoder

This block sits on the address path of a two-sided bus bridge. For each memory request it decides whether the bridge claims the request and forwards it to the other side. The decision rests on one 64-bit prefetchable window, set by four configuration fields that a simple write port loads. A request comes with its address, a flag that tells a single-address-cycle (32-bit) request from a dual-address-cycle (64-bit) one, and the side that issued it.

A request from the primary side is claimed and forwarded downstream when it hits the window. A request from the secondary side is claimed and forwarded upstream when it misses the window. A window whose lower end sits below 4 GB and whose upper end lies above it is handled by a split rule. Under that rule, 32-bit requests are compared only against the base and 64-bit requests only against the limit. The decision is registered and appears one clock after the request, marked by a valid strobe, together with the forwarding direction.

Top module: `prefetch_window_decoder`

## Requirements
- R1: After reset, all four window fields are zero, so the window covers 0h to FFFFFh, and the decision valid output is low.
- R2: A request presented in the cycle of a rising clock edge yields exactly one decision, with decValid high, in the following cycle. With no request, decValid is low and decClaim is low.
- R3: Writes at byte offset 24h load two fields: bits 15:4 go to base address bits 31:20, and bits 31:20 go to limit address bits 31:20. Writes at 28h load base address bits 63:32 and writes at 2Ch load limit address bits 63:32. Writes at any other offset change no decision.
- R4: Base address bits 19:0 are taken as zero and limit address bits 19:0 as all ones, which gives 1 MB granularity.
- R5: When the window does not straddle 4 GB, a primary request is claimed only if its address is at or above the base and at or below the limit.
- R6: When the window does not straddle 4 GB, a secondary request is claimed only if its address lies outside the window. A secondary request inside the window is not claimed.
- R7: When the 64-bit base is above the 64-bit limit, the window is empty: no primary request is claimed and every secondary request is claimed.
- R8: The window straddles 4 GB when the base upper field is zero and the limit upper field is nonzero. In that case a single-cycle request is compared against the base only: a primary request is claimed if its address is at or above the base, and a secondary request is claimed if its address is below the base.
- R9: In the straddle case a dual-cycle request is compared against the 64-bit limit only, whatever its relation to the base. A primary request is claimed if its address is at or below the limit, and a secondary request is claimed if its address is above the limit.
- R10: For a single-cycle request (reqDac low), reqAddr bits 63:32 are ignored and taken as zero.
- R11: decDown is 1 for a decision on a primary request and 0 for a decision on a secondary request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset of the dword written |
| cfgWdata | input | 32 | Configuration write data |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | 64 | Request address |
| reqDac | input | 1 | 1 = dual-address-cycle (64-bit) request, 0 = single-cycle |
| reqFromSec | input | 1 | 1 = request issued on the secondary side, 0 = primary |
| decValid | output | 1 | A decision is present this cycle |
| decClaim | output | 1 | The request is claimed and forwarded |
| decDown | output | 1 | 1 = forward downstream, 0 = forward upstream |

## Verification
The bench builds the block with its default parameters: a 64-bit address, 32-bit configuration dwords and 1 MB granularity. With these values the granule edges (addresses ending in FFFFFh and 00000h) are reachable from plain configuration writes, so the bench can probe each base and limit boundary one address apart. The 64-bit width also lets the bench place a window wholly above 4 GB, one that straddles 4 GB, and an inverted one. Against these it runs dual-cycle requests that sit below the base yet under the limit, and single-cycle requests that carry junk in their upper address bits.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  // Write strobes issued by the control toward the datapath registers.
  typedef struct packed {
    logic wrWindowLo;   // base/limit bits 31:GRAN in one dword
    logic wrBaseUp;     // base bits 63:32
    logic wrLimitUp;    // limit bits 63:32
  } cfgStrobe_t;

  // Comparison results returned by the datapath.
  typedef struct packed {
    logic straddle;     // base below 4GB, limit above
    logic enabled;      // base <= limit
    logic inWindow;     // enabled and base <= addr <= limit
    logic sacGeBase;    // low 32 address bits >= low 32 base bits
    logic dacLeLimit;   // 64-bit address <= 64-bit limit
  } cmpFlags_t;

endpackage

// File: rtl/pfw_datapath.sv
module pfw_datapath
  import pfw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CFG_W     = 32,
  parameter int GRAN_BITS = 20,
  parameter int BASE_LSB  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDac,
  output cmpFlags_t         flags
);

  localparam int LO_W = CFG_W - GRAN_BITS;
  localparam int UP_W = ADDR_W - CFG_W;

  logic [LO_W-1:0] baseLo, limitLo;
  logic [UP_W-1:0] baseUp, limitUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseLo  <= '0;
      limitLo <= '0;
      baseUp  <= '0;
      limitUp <= '0;
    end else begin
      if (strobe.wrWindowLo) begin
        baseLo  <= cfgWdata[BASE_LSB +: LO_W];
        limitLo <= cfgWdata[CFG_W-1 -: LO_W];
      end
      if (strobe.wrBaseUp)  baseUp  <= cfgWdata[UP_W-1:0];
      if (strobe.wrLimitUp) limitUp <= cfgWdata[UP_W-1:0];
    end
  end

  logic [ADDR_W-1:0] base64, limit64, addr64;
  logic              addrGeBase, addrLeLimit;

  always_comb begin
    base64  = {baseUp, baseLo, {GRAN_BITS{1'b0}}};
    limit64 = {limitUp, limitLo, {GRAN_BITS{1'b1}}};
    // A single-cycle request carries a 32-bit address only.
    addr64  = reqDac ? reqAddr : {{UP_W{1'b0}}, reqAddr[CFG_W-1:0]};
    addrGeBase  = (addr64 >= base64);
    addrLeLimit = (addr64 <= limit64);
    flags.straddle   = (baseUp == '0) && (limitUp != '0);
    flags.enabled    = (base64 <= limit64);
    flags.inWindow   = flags.enabled && addrGeBase && addrLeLimit;
    flags.sacGeBase  = (reqAddr[CFG_W-1:0] >= base64[CFG_W-1:0]);
    flags.dacLeLimit = addrLeLimit;
  end

  // R3: an upper field takes the written value on the next edge.
  p_base_up_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrBaseUp |=> (baseUp == $past(cfgWdata[UP_W-1:0])));
  p_limit_up_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLimitUp |=> (limitUp == $past(cfgWdata[UP_W-1:0])));
  // R3: without a strobe the fields hold.
  p_fields_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(baseUp) && $stable(limitUp) &&
                        $stable(baseLo) && $stable(limitLo)));
  // R8/R7: a straddling window can never be empty.
  p_straddle_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    flags.straddle |-> flags.enabled);

endmodule

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
  import pfw_pkg::*;
#(
  parameter int CFG_AW       = 8,
  parameter int OFF_WINDOWLO = 'h24,
  parameter int OFF_BASEUP   = 'h28,
  parameter int OFF_LIMITUP  = 'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              reqValid,
  input  logic              reqDac,
  input  logic              reqFromSec,
  input  cmpFlags_t         flags,
  output cfgStrobe_t        strobe,
  output logic              decValid,
  output logic              decClaim,
  output logic              decDown
);

  localparam logic [CFG_AW-1:0] A_WLO = CFG_AW'(OFF_WINDOWLO);
  localparam logic [CFG_AW-1:0] A_BUP = CFG_AW'(OFF_BASEUP);
  localparam logic [CFG_AW-1:0] A_LUP = CFG_AW'(OFF_LIMITUP);

  always_comb begin
    strobe.wrWindowLo = cfgWe && (cfgAddr == A_WLO);
    strobe.wrBaseUp   = cfgWe && (cfgAddr == A_BUP);
    strobe.wrLimitUp  = cfgWe && (cfgAddr == A_LUP);
  end

  logic hit, claimNext;

  always_comb begin
    if (flags.straddle) hit = reqDac ? flags.dacLeLimit : flags.sacGeBase;
    else                hit = flags.inWindow;
    claimNext = reqFromSec ? !hit : hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decClaim <= 1'b0;
      decDown  <= 1'b0;
    end else begin
      decValid <= reqValid;
      decClaim <= reqValid && claimNext;
      decDown  <= reqValid && !reqFromSec;
    end
  end

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!decValid && !decClaim));
  p_direction_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (decDown == !$past(reqFromSec)));
  p_sec_inside_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFromSec && !flags.straddle && flags.inWindow) |=> !decClaim);
  p_straddle_sac_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDac && flags.straddle)
      |=> (decClaim == ($past(flags.sacGeBase) ^ $past(reqFromSec))));
  p_straddle_dac_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDac && flags.straddle)
      |=> (decClaim == ($past(flags.dacLeLimit) ^ $past(reqFromSec))));
  p_empty_primary_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFromSec && !flags.enabled) |=> !decClaim);

endmodule

// File: rtl/prefetch_window_decoder.sv
module prefetch_window_decoder
  import pfw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int CFG_W     = 32,
  parameter int CFG_AW    = 8,
  parameter int GRAN_BITS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDac,
  input  logic              reqFromSec,
  output logic              decValid,
  output logic              decClaim,
  output logic              decDown
);

  cfgStrobe_t strobe;
  cmpFlags_t  flags;

  pfw_ctrl #(.CFG_AW(CFG_AW)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .reqValid(reqValid), .reqDac(reqDac), .reqFromSec(reqFromSec),
    .flags(flags), .strobe(strobe),
    .decValid(decValid), .decClaim(decClaim), .decDown(decDown)
  );

  pfw_datapath #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .GRAN_BITS(GRAN_BITS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWdata(cfgWdata),
    .reqAddr(reqAddr), .reqDac(reqDac), .flags(flags)
  );

endmodule

// File: tb/tb_prefetch_window_decoder.sv
module tb_prefetch_window_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        reqDac = 1'b0;
  logic        reqFromSec = 1'b0;
  logic        decValid, decClaim, decDown;

  always #5 clk = ~clk;

  prefetch_window_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqDac(reqDac), .reqFromSec(reqFromSec),
    .decValid(decValid), .decClaim(decClaim), .decDown(decDown)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  claim;
    logic  down;
    string tag;
  } exp_t;
  exp_t sb[$];

  // Bench shadow of the window fields, kept from the R3 map.
  logic [11:0] mBaseLo = '0, mLimitLo = '0;
  logic [31:0] mBaseUp = '0, mLimitUp = '0;

  function automatic logic modelClaim(logic [63:0] a, logic dac, logic sec);
    logic [63:0] eff, b, l;
    logic hit;
    eff = dac ? a : {32'h0, a[31:0]};
    b = {mBaseUp, mBaseLo, 20'h00000};
    l = {mLimitUp, mLimitLo, 20'hFFFFF};
    if (mBaseUp == 0 && mLimitUp != 0)
      hit = dac ? (eff <= l) : (eff[31:0] >= b[31:0]);
    else
      hit = (b <= l) && (eff >= b) && (eff <= l);
    return sec ? !hit : hit;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = off; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    case (off)
      8'h24: begin mBaseLo = d[15:4]; mLimitLo = d[31:20]; end
      8'h28: mBaseUp = d;
      8'h2C: mLimitUp = d;
      default: ;
    endcase
  endtask

  // Driver: present one request per call, push the expected result.
  task automatic sendReq(string tag, logic [63:0] a, logic dac, logic sec);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqDac = dac; reqFromSec = sec;
    e.claim = modelClaim(a, dac, sec);
    e.down = !sec;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    reqValid = 1'b0; reqAddr = '0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: each decision pops the oldest expectation (R2).
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && decValid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected decision actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, {decClaim, decDown}, {e.claim, e.down});
        end
      end else if (rstN && decClaim) begin
        check("R2 claim without valid", {decClaim, 1'b0}, 2'b00);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", {decValid, decClaim}, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid low after reset", {decValid, decClaim}, 2'b00);

    // R1/R4: reset window is 0..FFFFFh.
    sendReq("R1 reset window inside", 64'h8_0000, 1'b0, 1'b0);
    sendReq("R4 limit low ones", 64'hF_FFFF, 1'b0, 1'b0);
    sendReq("R4 first past limit", 64'h10_0000, 1'b0, 1'b0);
    sendReq("R11 secondary direction", 64'h10_0000, 1'b0, 1'b1);
    drain();

    // Window 1_2340_0000 .. 1_567F_FFFF (R3 map, R5, R6).
    cfgWrite(8'h24, (32'h567 << 20) | (32'h234 << 4));
    cfgWrite(8'h28, 32'h1);
    cfgWrite(8'h2C, 32'h1);
    sendReq("R5 primary dac inside", 64'h1_3000_0000, 1'b1, 1'b0);
    sendReq("R5 R4 base edge", 64'h1_2340_0000, 1'b1, 1'b0);
    sendReq("R5 below base", 64'h1_233F_FFFF, 1'b1, 1'b0);
    sendReq("R5 limit edge", 64'h1_567F_FFFF, 1'b1, 1'b0);
    sendReq("R5 above limit", 64'h1_5680_0000, 1'b1, 1'b0);
    sendReq("R6 secondary inside", 64'h1_3000_0000, 1'b1, 1'b1);
    sendReq("R6 secondary outside", 64'h1_5680_0000, 1'b1, 1'b1);
    sendReq("R6 secondary sac", 64'h3000_0000, 1'b0, 1'b1);
    sendReq("R10 sac upper bits ignored", 64'h1_3000_0000, 1'b0, 1'b0);
    drain();

    // R3: other offsets change nothing.
    cfgWrite(8'h30, 32'hFFFF_FFFF);
    cfgWrite(8'h20, 32'h0000_0000);
    cfgWrite(8'h25, 32'h0000_0000);
    sendReq("R3 ignored offsets inside", 64'h1_3000_0000, 1'b1, 1'b0);
    sendReq("R3 ignored offsets outside", 64'h1_233F_FFFF, 1'b1, 1'b0);
    drain();

    // R7: empty window (base 2_xxxx above limit 1_xxxx).
    cfgWrite(8'h28, 32'h2);
    sendReq("R7 primary empty", 64'h1_3000_0000, 1'b1, 1'b0);
    sendReq("R7 primary empty 2", 64'h2_3000_0000, 1'b1, 1'b0);
    sendReq("R7 secondary empty", 64'h2_3000_0000, 1'b1, 1'b1);
    drain();

    // Straddle: base 8000_0000, limit 3_001F_FFFF (R8, R9, R10).
    cfgWrite(8'h24, (32'h001 << 20) | (32'h800 << 4));
    cfgWrite(8'h28, 32'h0);
    cfgWrite(8'h2C, 32'h3);
    sendReq("R8 sac primary at base", 64'h8000_0000, 1'b0, 1'b0);
    sendReq("R8 sac primary below", 64'h7FFF_FFFF, 1'b0, 1'b0);
    sendReq("R8 sac secondary below", 64'h7FFF_FFFF, 1'b0, 1'b1);
    sendReq("R8 sac secondary at base", 64'h8000_0000, 1'b0, 1'b1);
    sendReq("R10 straddle sac junk upper", 64'hFFFF_FFFF_7000_0000, 1'b0, 1'b0);
    sendReq("R9 dac primary at limit", 64'h3_001F_FFFF, 1'b1, 1'b0);
    sendReq("R9 dac primary above", 64'h3_0020_0000, 1'b1, 1'b0);
    sendReq("R9 dac secondary at limit", 64'h3_001F_FFFF, 1'b1, 1'b1);
    sendReq("R9 dac secondary above", 64'h3_0020_0000, 1'b1, 1'b1);
    sendReq("R9 dac below base claimed", 64'h0000_1000, 1'b1, 1'b0);
    sendReq("R9 dac below base secondary", 64'h0000_1000, 1'b1, 1'b1);
    drain();

    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing decisions actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule